// File: doc/BRIEF.md
# Structured Parallel Stream Output Generator

This block turns 32-bit words, delivered on a valid/ready input, into a parallel output stream of one item per clock. The item is 8, 16 or 32 bits wide, picked at run time. In the structured mode the items form records of a configured length, and records form buffers of a configured count. Two strobe wires mark the first item of each record and the first record of each buffer. A one-cycle completion pulse follows the last item of every buffer. In the message mode each accepted word leaves as a single standalone item, with no record or buffer framing.

A narrow width splits each word into byte or halfword lanes, least significant lane first. The block takes a new word only once the previous word's lanes are all out. Input back-pressure rules:
- `in_ready` depends only on internal state, never on `in_valid`.
- A word moves on a clock edge where `in_valid` and `in_ready` are both high.
- Once the source raises `in_valid`, it keeps the signal high and `in_data` unchanged until that transfer happens.

The output has no back-pressure. When no word is available, `out_valid` falls for that cycle and the framing counters stay where they are.

Output can begin as soon as the block is enabled. Alternatively, it can wait for a rising edge on an external sync input, which passes through a configurable synchroniser chain first. The configuration inputs are expected to change only while the block is disabled.

Top module: `strm_out_gen`

## Requirements
- R1: Width code `cfg_width` selects the item size: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. At 8 and 16 bits each word leaves as 4 bytes or 2 halfwords, least significant first, zero-extended on `out_data`.
- R2: When words are always available, the block emits one item on every clock at every width, with no idle cycles.
- R3: In structured mode, `out_rec_start` is high with the first item of every record, where a record is `cfg_rec_len` items. At all other times it is low.
- R4: `out_buf_start` is high only together with `out_rec_start`, on the first record of each buffer, where a buffer is `cfg_rec_cnt` records.
- R5: `buf_done` pulses high for exactly one cycle, in the cycle after the last item of each buffer appears on the output.
- R6: If no word is available mid-record, `out_valid` and both strobes are low for that cycle, and the framing continues unchanged once words resume.
- R7: In message mode (`cfg_msg_mode` = 1), each accepted word gives exactly one item, its low 8, 16 or 32 bits. Both strobes and `buf_done` stay low.
- R8: With `cfg_sync_en` set, the enabled block keeps `in_ready` and `out_valid` low until `ext_sync` rises. It then starts a new buffer.
- R9: With `cfg_enable` low, `in_ready` is low from the next cycle and `out_valid` is low from the cycle after. Re-enabling restarts at the first record of a new buffer.
- R10: After reset, `in_ready`, `out_valid`, both strobes and `buf_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Run enable; low clears all progress |
| cfg_sync_en | input | 1 | Wait for an `ext_sync` rising edge before output starts |
| cfg_msg_mode | input | 1 | 1 = message mode, 0 = structured stream |
| cfg_width | input | 2 | Item width code (0: 8, 1: 16, 2/3: 32) |
| cfg_rec_len | input | LEN_W (16) | Items per record (0 is treated as 1) |
| cfg_rec_cnt | input | LEN_W (16) | Records per buffer (0 is treated as 1) |
| ext_sync | input | 1 | External start synchronisation input |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output item valid |
| out_data | output | 32 | Output item, zero-extended |
| out_rec_start | output | 1 | First item of a record |
| out_buf_start | output | 1 | First item of a buffer |
| buf_done | output | 1 | One-cycle pulse after the last item of a buffer |

## Verification
The assertions rely on two conditions: the configuration inputs stay still while the block is enabled, and `ext_sync` is a clean level. Under those conditions the strobe, mode and width relations can be judged one cycle back from the registered outputs. The bench changes the width, mode, lengths and sync selection only at a falling edge while `cfg_enable` is low, before it raises the enable. It keeps `in_valid` and `in_data` steady until `in_ready` accepts the word, and inserts its gaps only after a transfer.

// File: rtl/strm_out_pkg.sv
package strm_out_pkg;

  localparam int WORD_W = 32;
  localparam int LANE_W = 2;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2
  } wid_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } gen_state_e;

  // Index of the final lane of a word for a given width code and mode.
  function automatic logic [LANE_W-1:0] final_lane(input logic [1:0] wcode,
                                                    input logic      msg);
    if (msg)                          return '0;
    else if (wcode == WID_8)          return 2'd3;
    else if (wcode == WID_16)         return 2'd1;
    else                              return '0;
  endfunction

endpackage

// File: rtl/strm_sync_ctrl.sv
module strm_sync_ctrl
  import strm_out_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sync_en,
  input  logic ext_sync,
  output logic run
);

  logic       sync_s;
  logic       sync_prev;
  logic       sync_rise;
  gen_state_e state_q, state_d;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign sync_s = ext_sync;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], ext_sync};
      end
      assign sync_s = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_prev <= 1'b0;
    else        sync_prev <= sync_s;
  end

  assign sync_rise = sync_s & ~sync_prev;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (enable) state_d = sync_en ? ST_WAIT : ST_RUN;
      ST_WAIT: begin
        if (!enable)        state_d = ST_IDLE;
        else if (sync_rise) state_d = ST_RUN;
      end
      ST_RUN:  if (!enable) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign run = (state_q == ST_RUN);

endmodule

// File: rtl/strm_lane_ser.sv
module strm_lane_ser
  import strm_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [1:0]        wcode,
  input  logic              msg,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              emit,
  output logic [WORD_W-1:0] item
);

  logic              hold_vld;
  logic [WORD_W-1:0] hold_word;
  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] cur_word;
  logic [LANE_W-1:0] cur_lane;
  logic [LANE_W-1:0] last_lane;
  logic [WORD_W-1:0] sh8, sh16;

  assign last_lane = final_lane(wcode, msg);
  assign in_ready  = run & ~hold_vld;
  assign emit      = run & (hold_vld | in_valid);
  assign cur_word  = hold_vld ? hold_word : in_data;
  assign cur_lane  = hold_vld ? lane_q : '0;

  assign sh8  = cur_word >> {cur_lane, 3'b000};
  assign sh16 = cur_word >> {cur_lane[0], 4'b0000};

  always_comb begin
    if (wcode == WID_8)       item = {{(WORD_W-8){1'b0}},  sh8[7:0]};
    else if (wcode == WID_16) item = {{(WORD_W-16){1'b0}}, sh16[15:0]};
    else                      item = cur_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_word <= '0;
      lane_q    <= '0;
    end else if (!run) begin
      hold_vld <= 1'b0;
      lane_q   <= '0;
    end else if (emit) begin
      if (cur_lane == last_lane) begin
        hold_vld <= 1'b0;
        lane_q   <= '0;
      end else begin
        hold_vld  <= 1'b1;
        hold_word <= cur_word;
        lane_q    <= LANE_W'(cur_lane + 1'b1);
      end
    end
  end

endmodule

// File: rtl/strm_frame_cnt.sv
module strm_frame_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             msg,
  input  logic             emit,
  input  logic [LEN_W-1:0] rec_len,
  input  logic [LEN_W-1:0] rec_cnt,
  output logic             rec_start,
  output logic             buf_start,
  output logic             buf_end
);

  localparam int EXT_W = LEN_W + 1;

  logic [LEN_W-1:0] item_idx, rec_idx;
  logic             item_last, rec_last, framed;

  assign framed    = emit & ~msg;
  assign item_last = ({1'b0, item_idx} + EXT_W'(1)) >= {1'b0, rec_len};
  assign rec_last  = ({1'b0, rec_idx}  + EXT_W'(1)) >= {1'b0, rec_cnt};
  assign rec_start = framed & (item_idx == '0);
  assign buf_start = rec_start & (rec_idx == '0);
  assign buf_end   = framed & item_last & rec_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      item_idx <= '0;
      rec_idx  <= '0;
    end else if (!run) begin
      item_idx <= '0;
      rec_idx  <= '0;
    end else if (framed) begin
      if (item_last) begin
        item_idx <= '0;
        rec_idx  <= rec_last ? '0 : LEN_W'(rec_idx + 1'b1);
      end else begin
        item_idx <= LEN_W'(item_idx + 1'b1);
      end
    end
  end

endmodule

// File: rtl/strm_out_gen.sv
module strm_out_gen
  import strm_out_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_sync_en,
  input  logic              cfg_msg_mode,
  input  logic [1:0]        cfg_width,
  input  logic [LEN_W-1:0]  cfg_rec_len,
  input  logic [LEN_W-1:0]  cfg_rec_cnt,
  input  logic              ext_sync,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_rec_start,
  output logic              out_buf_start,
  output logic              buf_done
);

  logic              run, emit, rs, bs, be, end_q;
  logic [WORD_W-1:0] item;

  strm_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .sync_en(cfg_sync_en),
    .ext_sync(ext_sync), .run(run)
  );

  strm_lane_ser u_ser (
    .clk(clk), .rst_n(rst_n), .run(run), .wcode(cfg_width), .msg(cfg_msg_mode),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .emit(emit), .item(item)
  );

  strm_frame_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .msg(cfg_msg_mode), .emit(emit),
    .rec_len(cfg_rec_len), .rec_cnt(cfg_rec_cnt),
    .rec_start(rs), .buf_start(bs), .buf_end(be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_rec_start <= 1'b0;
      out_buf_start <= 1'b0;
      end_q         <= 1'b0;
      buf_done      <= 1'b0;
    end else begin
      out_valid     <= emit;
      out_data      <= emit ? item : '0;
      out_rec_start <= rs;
      out_buf_start <= bs;
      end_q         <= be;
      buf_done      <= end_q;
    end
  end

endmodule

// File: rtl/strm_out_gen_chk.sv
module strm_out_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_enable,
  input logic        cfg_msg_mode,
  input logic [1:0]  cfg_width,
  input logic        in_ready,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        out_rec_start,
  input logic        out_buf_start,
  input logic        buf_done
);

  p_rec_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_rec_start |-> out_valid);

  p_buf_in_rec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_buf_start |-> out_rec_start);

  p_done_after_item_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> $past(out_valid));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> !buf_done);

  p_msg_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_msg_mode) |-> !out_rec_start && !out_buf_start);

  p_byte_zero_ext_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_width) == 2'd0) |-> out_data[31:8] == 24'd0);

  p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !in_ready ##1 !out_valid);

endmodule

bind strm_out_gen strm_out_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_msg_mode(cfg_msg_mode),
  .cfg_width(cfg_width), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_rec_start(out_rec_start),
  .out_buf_start(out_buf_start), .buf_done(buf_done)
);

// File: tb/strm_out_gen_tb.sv
`timescale 1ns/1ps
module strm_out_gen_tb;

  localparam int LEN_W = 16;
  localparam int MAXN  = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_enable = 1'b0, cfg_sync_en = 1'b0, cfg_msg_mode = 1'b0;
  logic [1:0]       cfg_width = 2'd2;
  logic [LEN_W-1:0] cfg_rec_len = 16'd1, cfg_rec_cnt = 16'd1;
  logic             ext_sync = 1'b0, in_valid = 1'b0;
  logic [31:0]      in_data = '0;
  logic             in_ready, out_valid, out_rec_start, out_buf_start, buf_done;
  logic [31:0]      out_data;

  strm_out_gen #(.LEN_W(LEN_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_sync_en(cfg_sync_en),
    .cfg_msg_mode(cfg_msg_mode), .cfg_width(cfg_width), .cfg_rec_len(cfg_rec_len),
    .cfg_rec_cnt(cfg_rec_cnt), .ext_sync(ext_sync), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_rec_start(out_rec_start),
    .out_buf_start(out_buf_start), .buf_done(buf_done)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done_flag = 0;
  bit cap_on = 0;
  int n_items = 0, n_done = 0, strobe_bad = 0;
  logic [31:0] cap_data [MAXN];
  bit          cap_rs   [MAXN];
  bit          cap_bs   [MAXN];
  int          cap_cyc  [MAXN];
  int          done_pos [MAXN];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cap_on) begin
      if (buf_done && n_done < MAXN) begin
        done_pos[n_done] = n_items;
        n_done++;
      end
      if (out_valid) begin
        if (n_items < MAXN) begin
          cap_data[n_items] = out_data;
          cap_rs[n_items]   = out_rec_start;
          cap_bs[n_items]   = out_buf_start;
          cap_cyc[n_items]  = cyc;
        end
        n_items++;
      end else if (out_rec_start || out_buf_start) begin
        strobe_bad++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int i, input int seed);
    return {8'(seed), 8'(i + 16), ~8'(i), 8'(i) ^ 8'h5A};
  endfunction

  task automatic setup(input logic [1:0] w, input bit msg, input bit sy,
                       input int rl, input int rc);
    @(negedge clk);
    cfg_enable = 1'b0;
    cfg_width = w; cfg_msg_mode = msg; cfg_sync_en = sy;
    cfg_rec_len = LEN_W'(rl); cfg_rec_cnt = LEN_W'(rc);
    repeat (2) @(negedge clk);
    n_items = 0; n_done = 0; strobe_bad = 0; cap_on = 1;
    cfg_enable = 1'b1;
  endtask

  task automatic drive_words(input int n, input int seed, input int gap_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = word_of(i, seed);
      forever begin
        #1;
        if (in_ready) break;
        @(negedge clk);
      end
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    repeat (6) @(negedge clk);
    cfg_enable = 1'b0;
    repeat (4) @(negedge clk);
    cap_on = 0;
  endtask

  // Compares the captured stream against the framing rules.
  task automatic check_stream(input int nw, input int seed, input logic [1:0] w,
                              input bit msg, input int rl, input int rc,
                              input bit want_tput);
    int lanes, exp_n, k, per_buf, exp_done;
    logic [31:0] e, wd;
    lanes = msg ? 1 : (w == 2'd0 ? 4 : (w == 2'd1 ? 2 : 1));
    exp_n = nw * lanes;
    chk(n_items == exp_n, "R1", "item count", 32'(n_items), 32'(exp_n));
    k = 0;
    for (int i = 0; i < nw; i++) begin
      wd = word_of(i, seed);
      for (int l = 0; l < lanes; l++) begin
        if (w == 2'd0)      e = {24'd0, wd[l*8 +: 8]};
        else if (w == 2'd1) e = {16'd0, wd[l*16 +: 16]};
        else                e = wd;
        if (k < n_items && k < MAXN) begin
          chk(cap_data[k] == e, msg ? "R7" : "R1", "item data", cap_data[k], e);
          chk(cap_rs[k] == (!msg && (k % rl) == 0), msg ? "R7" : "R3",
              "record strobe", 32'(cap_rs[k]), 32'(!msg && (k % rl) == 0));
          chk(cap_bs[k] == (!msg && (k % (rl*rc)) == 0), msg ? "R7" : "R4",
              "buffer strobe", 32'(cap_bs[k]), 32'(!msg && (k % (rl*rc)) == 0));
          if (want_tput && k > 0)
            chk(cap_cyc[k] - cap_cyc[k-1] == 1, "R2", "item spacing",
                32'(cap_cyc[k] - cap_cyc[k-1]), 32'd1);
        end
        k++;
      end
    end
    per_buf  = rl * rc;
    exp_done = msg ? 0 : exp_n / per_buf;
    chk(n_done == exp_done, msg ? "R7" : "R5", "done count",
        32'(n_done), 32'(exp_done));
    for (int j = 0; j < n_done && j < exp_done; j++)
      chk(done_pos[j] == (j+1)*per_buf, "R5", "done position",
          32'(done_pos[j]), 32'((j+1)*per_buf));
    chk(strobe_bad == 0, "R6", "strobe without valid", 32'(strobe_bad), 32'd0);
  endtask

  task automatic t_reset();
    chk(!in_ready && !out_valid && !out_rec_start && !out_buf_start && !buf_done,
        "R10", "outputs in reset",
        {27'd0, in_ready, out_valid, out_rec_start, out_buf_start, buf_done}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid && !buf_done, "R10", "idle after reset",
        {29'd0, in_ready, out_valid, buf_done}, 32'd0);
  endtask

  task automatic t_wide();
    setup(2'd2, 0, 0, 3, 2);
    drive_words(12, 1, 0);
    finish_run();
    check_stream(12, 1, 2'd2, 0, 3, 2, 1);
  endtask

  task automatic t_byte();
    setup(2'd0, 0, 0, 5, 2);
    drive_words(5, 2, 0);
    finish_run();
    check_stream(5, 2, 2'd0, 0, 5, 2, 1);
  endtask

  task automatic t_gaps();
    setup(2'd1, 0, 0, 3, 3);
    drive_words(9, 3, 2);
    finish_run();
    check_stream(9, 3, 2'd1, 0, 3, 3, 0);
    chk(cap_cyc[17] - cap_cyc[0] > 17, "R6", "gaps stretch stream",
        32'(cap_cyc[17] - cap_cyc[0]), 32'd18);
  endtask

  task automatic t_msg();
    setup(2'd1, 1, 0, 2, 1);
    drive_words(6, 4, 0);
    finish_run();
    check_stream(6, 4, 2'd1, 1, 2, 1, 0);
  endtask

  task automatic t_sync();
    int bad_rdy;
    setup(2'd2, 0, 1, 2, 2);
    bad_rdy = 0;
    repeat (20) begin
      @(negedge clk);
      if (in_ready) bad_rdy++;
    end
    chk(bad_rdy == 0, "R8", "ready before sync", 32'(bad_rdy), 32'd0);
    chk(n_items == 0, "R8", "items before sync", 32'(n_items), 32'd0);
    ext_sync = 1'b1;
    drive_words(4, 5, 0);
    ext_sync = 1'b0;
    finish_run();
    check_stream(4, 5, 2'd2, 0, 2, 2, 1);
  endtask

  task automatic t_restart();
    int bad;
    setup(2'd2, 0, 0, 4, 2);
    drive_words(6, 6, 0);
    @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk);
    bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (in_ready || out_valid) bad++;
    end
    chk(bad == 0, "R9", "quiet while disabled", 32'(bad), 32'd0);
    chk(n_done == 0, "R9", "no done for cut buffer", 32'(n_done), 32'd0);
    n_items = 0; n_done = 0; strobe_bad = 0;
    cfg_enable = 1'b1;
    drive_words(8, 7, 0);
    finish_run();
    check_stream(8, 7, 2'd2, 0, 4, 2, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_wide();
    t_byte();
    t_gaps();
    t_msg();
    t_sync();
    t_restart();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule